// File: doc/BRIEF.md
# Leading-Ones Counter with Seven-Segment Digit

This block is purely combinational. It scans an input vector from its most significant bit toward bit 0 and counts the ones it passes until it meets the first zero. It gives the count in two forms. One is an unsigned binary value. The other is a segment pattern that drives a single seven-segment digit.

The input width is a parameter. The width of the binary output is derived from it as `$clog2(WIDTH_IN+1)`. Because a single digit shows at most 9, the input width is limited to the range 1 to 9. The default configuration uses eight input bits, which gives a four-bit count. The block has no clock, no reset and no stored state. A change on the input reaches both outputs within the same time step.

Top module: `lead_ones_display`

## Requirements
- R1: `y_o` equals the number of consecutive ones in `x_i` counted downward from bit `WIDTH_IN-1`, stopping at the first zero.
- R2: When every bit of `x_i` is one, `y_o` equals `WIDTH_IN` (8 by default).
- R3: When bit `WIDTH_IN-1` of `x_i` is zero, `y_o` is 0.
- R4: Bits of `x_i` below the first zero have no effect on either output.
- R5: `seg_o` is active-high, with bit 6 = segment a down to bit 0 = segment g. It shows the digit of `y_o` using 0=7E, 1=30, 2=6D, 3=79, 4=33, 5=5B, 6=5F, 7=70, 8=7F, 9=7B (hex).
- R6: `y_o` is `$clog2(WIDTH_IN+1)` bits wide, which is 4 for the default width. Elaboration rejects a `WIDTH_IN` outside the range 1 to 9.
- R7: Both outputs follow `x_i` combinationally, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | WIDTH_IN | Vector scanned from its MSB |
| y_o | output | $clog2(WIDTH_IN+1) | Count of leading ones, unsigned |
| seg_o | output | 7 | Active-high segments a..g, with a at bit 6 |

## Verification
The checker takes it for granted that `x_i` carries only known 0/1 values. It also assumes the block is built with a width of at most 9, so every count maps to a single digit. The checker evaluates nothing while the input holds unknown bits. The bench drives every one of the 256 input codes of the default width, plus directed patterns whose low bits differ below the first zero. Every stimulus is therefore a fully known value inside the legal range.

// File: rtl/lone_pkg.sv
package lone_pkg;

  localparam int unsigned MAX_WIDTH = 9;
  localparam int unsigned SEG_W     = 7;

  // active-high, bit 6 = a ... bit 0 = g
  function automatic logic [SEG_W-1:0] digit_to_seg(input logic [3:0] d);
    logic [SEG_W-1:0] s;
    unique case (d)
      4'd0:    s = 7'h7E;
      4'd1:    s = 7'h30;
      4'd2:    s = 7'h6D;
      4'd3:    s = 7'h79;
      4'd4:    s = 7'h33;
      4'd5:    s = 7'h5B;
      4'd6:    s = 7'h5F;
      4'd7:    s = 7'h70;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h7B;
      default: s = 7'h00;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/lone_run_count.sv
module lone_run_count #(
  parameter int unsigned WIDTH_IN = 8,
  localparam int unsigned CNT_W   = $clog2(WIDTH_IN + 1)
) (
  input  logic [WIDTH_IN-1:0] x_i,
  output logic [CNT_W-1:0]    cnt_o
);

  // run[i] high while every bit from MSB down to i is one (thermometer)
  logic [WIDTH_IN-1:0] run;

  assign run[WIDTH_IN-1] = x_i[WIDTH_IN-1];

  for (genvar i = 0; i < WIDTH_IN - 1; i++) begin : g_run
    assign run[i] = run[i+1] & x_i[i];
  end

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < WIDTH_IN; i++) begin
      cnt_o = cnt_o + CNT_W'(run[i]);
    end
  end

endmodule

// File: rtl/lone_seg_decode.sv
module lone_seg_decode
  import lone_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic [SEG_W-1:0] seg_o
);

  logic [3:0] digit;

  always_comb begin
    digit = 4'(cnt_i);
    seg_o = digit_to_seg(digit);
  end

endmodule

// File: rtl/lead_ones_display.sv
module lead_ones_display
  import lone_pkg::*;
#(
  parameter int unsigned WIDTH_IN = 8
) (
  input  logic [WIDTH_IN-1:0]              x_i,
  output logic [$clog2(WIDTH_IN+1)-1:0]    y_o,
  output logic [6:0]                       seg_o
);

  localparam int unsigned CNT_W = $clog2(WIDTH_IN + 1);

  if (WIDTH_IN < 1 || WIDTH_IN > MAX_WIDTH) begin : g_bad_width
    $error("lead_ones_display: WIDTH_IN must be 1..9 for one digit");
  end

  logic [CNT_W-1:0] cnt;

  lone_run_count #(
    .WIDTH_IN (WIDTH_IN)
  ) u_count (
    .x_i   (x_i),
    .cnt_o (cnt)
  );

  lone_seg_decode #(
    .CNT_W (CNT_W)
  ) u_seg (
    .cnt_i (cnt),
    .seg_o (seg_o)
  );

  assign y_o = cnt;

endmodule

// File: rtl/lead_ones_display_chk.sv
module lead_ones_display_chk #(
  parameter int unsigned WIDTH_IN = 8
) (
  input logic [WIDTH_IN-1:0]           x_i,
  input logic [$clog2(WIDTH_IN+1)-1:0] y_o,
  input logic [6:0]                    seg_o
);

  always_comb begin
    if (!$isunknown(x_i)) begin
      AST_COUNT_BOUND: assert (int'(y_o) <= int'(WIDTH_IN));                         // R1
      AST_STOP_AT_ZERO: assert (int'(y_o) == int'(WIDTH_IN) ||
                                x_i[WIDTH_IN - 1 - int'(y_o)] == 1'b0);             // R1
      AST_LAST_ONE: assert (y_o == '0 || x_i[WIDTH_IN - int'(y_o)] == 1'b1);        // R1
      AST_ALL_ONES: assert (!(&x_i) || int'(y_o) == int'(WIDTH_IN));                // R2
      AST_MSB_ZERO: assert (x_i[WIDTH_IN-1] || y_o == '0);                          // R3
      AST_SEG_LIT: assert (seg_o != 7'h00);                                         // R5
      AST_SEG_ZERO: assert (y_o != '0 || seg_o == 7'h7E);                           // R5
      AST_SEG_EIGHT: assert (int'(y_o) != 8 || seg_o == 7'h7F);                     // R5
    end
  end

endmodule

bind lead_ones_display lead_ones_display_chk #(
  .WIDTH_IN (WIDTH_IN)
) u_chk (
  .x_i   (x_i),
  .y_o   (y_o),
  .seg_o (seg_o)
);

// File: tb/lead_ones_display_bench.sv
`timescale 1ns/1ps
module lead_ones_display_bench;

  localparam int unsigned W  = 8;
  localparam int unsigned YW = $clog2(W + 1);

  logic          clk;
  logic [W-1:0]  x;
  logic [YW-1:0] y;
  logic [6:0]    seg;

  int n_chk  = 0;
  int n_fail = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  lead_ones_display #(.WIDTH_IN(W)) u_lead_ones_display (
    .x_i   (x),
    .y_o   (y),
    .seg_o (seg)
  );

  function automatic int exp_count(input logic [W-1:0] v);
    int n = 0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!v[i]) break;
      n++;
    end
    return n;
  endfunction

  function automatic logic [6:0] exp_seg(input int d);
    case (d)
      0: return 7'h7E;  1: return 7'h30;  2: return 7'h6D;  3: return 7'h79;
      4: return 7'h33;  5: return 7'h5B;  6: return 7'h5F;  7: return 7'h70;
      8: return 7'h7F;  9: return 7'h7B;
      default: return 7'h00;
    endcase
  endfunction

  task automatic check_int(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s x=%b actual=%0d expected=%0d", req, x, act, expv);
    end
  endtask

  task automatic apply(input logic [W-1:0] v);
    @(posedge clk);
    x = v;
    @(negedge clk);
  endtask

  initial begin
    x = '0;
    @(negedge clk);
    // all-zero start value: R3, R5
    check_int("R3", int'(y), 0);
    check_int("R5", int'(seg), int'(exp_seg(0)));
    // R6 output width
    check_int("R6", $bits(y), 4);

    // R1 / R5 / R7 exhaustive sweep, sampled one half period after the input change
    for (int v = 0; v < (1 << W); v++) begin
      apply(W'(v));
      check_int("R1", int'(y), exp_count(W'(v)));
      check_int("R5", int'(seg), int'(exp_seg(exp_count(W'(v)))));
    end

    // R7: output follows input within the same step, no clock edge needed
    x = 8'b1110_0000;
    #0.5;
    check_int("R7", int'(y), 3);

    apply('1);
    check_int("R2", int'(y), 8);
    check_int("R2", int'(seg), 32'h7F);

    apply(8'b0111_1111);
    check_int("R3", int'(y), 0);
    apply(8'b0000_0001);
    check_int("R3", int'(y), 0);

    // R4: bits below the first zero do not matter
    for (int lo = 0; lo < 16; lo++) begin
      apply({4'b1101, 4'(lo)});
      check_int("R4", int'(y), 2);
      check_int("R4", int'(seg), 32'h6D);
    end
    apply(8'b1111_1110);
    check_int("R4", int'(y), 7);
    check_int("R5", int'(seg), 32'h70);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule